// File: doc/BRIEF.md
# Host-Port Breakpoint and Event Interrupt Router

This block sits between an external host access port and an embedded CPU. It keeps two 16-bit control words: a debug breakpoint address and an event routing word. The host reads and writes both words through a simple register-select/strobe port. The CPU can read both words through its own port, but any CPU write attempt is discarded.

The block compares the CPU program counter with the stored breakpoint address. On a match with a non-zero address, it sets a sticky breakpoint interrupt. That interrupt stays raised until the host writes zero into the breakpoint word.

The routing word steers ten USB-controller event sources. Each source goes either to the host (the combined host interrupt and a per-source host status vector) or to that source's CPU interrupt line. The two start/end-of-frame channels are the exception: each has a separate CPU enable bit. Per-source enables arrive as inputs.

Top module: `hbir_top`

## Requirements
- R1: After reset the breakpoint word reads 0x0000, the routing word reads 0x1400 (bits 12 and 10 set), and bkpt_irq, host_irq, host_stat and cpu_irq are all low.
- R2: A host write with hst_wr=1 updates the breakpoint word when hst_sel=0 and the routing word when hst_sel=1, taking effect at the clock edge. Both ports return the selected word combinationally: hst_rdata for hst_sel and cpu_rdata for cpu_sel.
- R3: A CPU write (cpu_wr=1) never changes either word and never clears a raised breakpoint interrupt.
- R4: When cpu_pc equals a non-zero breakpoint word, bkpt_irq is high from the next clock edge. A zero breakpoint word never sets it, even when cpu_pc is 0.
- R5: bkpt_irq stays high after cpu_pc moves away and after a non-zero address is rewritten. It falls at the edge where the host writes 0x0000 to the breakpoint word.
- R6: Bit 5 of the routing word is reserved and always reads 0, whatever value is written.
- R7: Sources are indexed as follows: 0=VBUS (bit 15), 1=ID (bit 14), 2=frame channel 2 (bit 13), 3=frame channel 1 (bit 11), 4=reset 2 (bit 9), 5=reset 1 (bit 2), 6=resume 2 (bit 7), 7=resume 1 (bit 6), 8=done 2 (bit 4), 9=done 1 (bit 3). host_stat[i] is src_evt[i] AND src_en[i] AND the source's routing bit. host_irq is the OR of host_stat.
- R8: For every source other than 2 and 3, cpu_irq[i] is src_evt[i] AND src_en[i] AND NOT the source's routing bit.
- R9: cpu_irq[2] is gated by routing bit 12 and cpu_irq[3] by routing bit 10, independently of bits 13 and 11.
- R10: Routing bits 8 and 0 are stored and read back but change no interrupt output.
- R11: A source with src_en[i]=0 drives neither host_stat[i], cpu_irq[i] nor host_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_sel | input | 1 | Host word select: 0 breakpoint, 1 routing |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data of selected word |
| cpu_sel | input | 1 | CPU word select: 0 breakpoint, 1 routing |
| cpu_wr | input | 1 | CPU write strobe (discarded) |
| cpu_wdata | input | 16 | CPU write data (discarded) |
| cpu_rdata | output | 16 | CPU read data of selected word |
| cpu_pc | input | 16 | CPU program counter |
| src_evt | input | 10 | Raw event per source |
| src_en | input | 10 | Enable per source |
| host_irq | output | 1 | Combined host interrupt |
| host_stat | output | 10 | Per-source events routed to the host |
| cpu_irq | output | 10 | Per-source CPU interrupts |
| bkpt_irq | output | 1 | Sticky breakpoint interrupt |

## Verification
Several properties are checked on every cycle by assertions: the breakpoint flag sets after a non-zero match, holds, and clears after a zero write; a zero address never arms it; neither word moves without a host strobe; bit 5 stays zero; disabled sources reach no output; and no non-frame source reaches both destinations at once. Other behaviours can only be shown by the bench's scenarios. These are the exact reset values, read-back through both ports, the per-source bit mapping, the separate frame-channel CPU gates, and the swap bits having no effect on routing.

// File: rtl/hbir_pkg.sv
package hbir_pkg;
  localparam int DW    = 16;
  localparam int NSRC  = 10;

  localparam logic [DW-1:0]   RT_RESET = 16'h1400;
  localparam logic [DW-1:0]   RT_WMASK = 16'hFFDF;
  localparam logic [NSRC-1:0] SOF_SET  = 10'b00_0000_1100;

  typedef enum logic { SEL_BKPT = 1'b0, SEL_ROUTE = 1'b1 } wsel_e;

  function automatic int host_pos(input int idx);
    case (idx)
      0: return 15;
      1: return 14;
      2: return 13;
      3: return 11;
      4: return 9;
      5: return 2;
      6: return 7;
      7: return 6;
      8: return 4;
      9: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int cpu_pos(input int idx);
    case (idx)
      2: return 12;
      3: return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/hbir_regs.sv
module hbir_regs
  import hbir_pkg::*;
#(
  parameter int              W        = DW,
  parameter int              NREQ     = 2,
  parameter logic [NREQ-1:0] WR_ALLOW = 2'b01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NREQ-1:0]     req_sel,
  input  logic [NREQ-1:0]     req_wr,
  input  logic [NREQ*W-1:0]   req_wdata,
  output logic [NREQ*W-1:0]   req_rdata,
  output logic [W-1:0]        bp_q,
  output logic [W-1:0]        rt_q,
  output logic                bp_clr
);
  logic [W-1:0] bp_d, rt_d;
  logic         wr_en;

  always_comb begin
    bp_d   = bp_q;
    rt_d   = rt_q;
    bp_clr = 1'b0;
    wr_en  = 1'b0;
    for (int r = 0; r < NREQ; r++) begin
      if (WR_ALLOW[r] && req_wr[r] && !wr_en) begin
        wr_en = 1'b1;
        if (req_sel[r] == SEL_ROUTE) begin
          rt_d = req_wdata[r*W +: W] & RT_WMASK[W-1:0];
        end else begin
          bp_d   = req_wdata[r*W +: W];
          bp_clr = (req_wdata[r*W +: W] == '0);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q <= '0;
      rt_q <= RT_RESET[W-1:0];
    end else if (wr_en) begin
      bp_q <= bp_d;
      rt_q <= rt_d;
    end
  end

  for (genvar r = 0; r < NREQ; r++) begin : g_rd
    assign req_rdata[r*W +: W] = req_sel[r] ? rt_q : bp_q;
  end

  AST_WORDS_NEED_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(req_wr & WR_ALLOW)) |=> ($stable(bp_q) && $stable(rt_q))); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rt_q[5] == 1'b0); // R6
endmodule

// File: rtl/hbir_bkpt.sv
module hbir_bkpt
  import hbir_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] addr,
  input  logic         clr,
  output logic         flag
);
  logic hit, flag_d;

  always_comb begin
    hit    = (addr != '0) && (pc == addr);
    flag_d = flag;
    if (clr)      flag_d = 1'b0;
    else if (hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  AST_BKPT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != '0 && pc == addr && !clr) |=> flag); // R4
  AST_BKPT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0 && !flag) |=> !flag); // R4
  AST_BKPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R5
  AST_BKPT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag); // R5
endmodule

// File: rtl/hbir_route.sv
module hbir_route
  import hbir_pkg::*;
#(
  parameter int W = DW,
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rt,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  output logic [N-1:0] host_stat,
  output logic [N-1:0] cpu_irq,
  output logic         host_irq
);
  logic [N-1:0] live;
  assign live = evt & en;

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam int HP = host_pos(i);
    localparam int CP = cpu_pos(i);
    assign host_stat[i] = live[i] & rt[HP];
    if (SOF_SET[i]) begin : g_sof
      assign cpu_irq[i] = live[i] & rt[CP];
    end else begin : g_plain
      assign cpu_irq[i] = live[i] & ~rt[HP];
    end
  end

  assign host_irq = |host_stat;

  AST_HOST_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> |(evt & en)); // R7
  AST_PLAIN_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stat & cpu_irq & ~SOF_SET[N-1:0]) == '0); // R8
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_stat | cpu_irq) & ~en) == '0); // R11
endmodule

// File: rtl/hbir_top.sv
module hbir_top
  import hbir_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hst_sel,
  input  logic            hst_wr,
  input  logic [DW-1:0]   hst_wdata,
  output logic [DW-1:0]   hst_rdata,
  input  logic            cpu_sel,
  input  logic            cpu_wr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata,
  input  logic [DW-1:0]   cpu_pc,
  input  logic [NSRC-1:0] src_evt,
  input  logic [NSRC-1:0] src_en,
  output logic            host_irq,
  output logic [NSRC-1:0] host_stat,
  output logic [NSRC-1:0] cpu_irq,
  output logic            bkpt_irq
);
  logic [1:0]      rst_sync;
  logic            rst_core_n;
  logic [DW-1:0]   bp_q, rt_q;
  logic            bp_clr;
  logic [2*DW-1:0] rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  hbir_regs #(.W(DW), .NREQ(2), .WR_ALLOW(2'b01)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_sel   ({cpu_sel, hst_sel}),
    .req_wr    ({cpu_wr, hst_wr}),
    .req_wdata ({cpu_wdata, hst_wdata}),
    .req_rdata (rdata),
    .bp_q      (bp_q),
    .rt_q      (rt_q),
    .bp_clr    (bp_clr)
  );
  assign hst_rdata = rdata[DW-1:0];
  assign cpu_rdata = rdata[2*DW-1:DW];

  hbir_bkpt #(.W(DW)) u_bkpt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .pc    (cpu_pc),
    .addr  (bp_q),
    .clr   (bp_clr),
    .flag  (bkpt_irq)
  );

  hbir_route #(.W(DW), .N(NSRC)) u_route (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rt        (rt_q),
    .evt       (src_evt),
    .en        (src_en),
    .host_stat (host_stat),
    .cpu_irq   (cpu_irq),
    .host_irq  (host_irq)
  );
endmodule

// File: tb/hbir_top_bench.sv
module hbir_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_sel = 1'b0, hst_wr = 1'b0, cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [15:0] hst_wdata = '0, cpu_wdata = '0, cpu_pc = '0;
  logic [15:0] hst_rdata, cpu_rdata;
  logic [9:0]  src_evt = '0, src_en = '0, host_stat, cpu_irq;
  logic        host_irq, bkpt_irq;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  hbir_top u_hbir_top (
    .clk(clk), .rst_n(rst_n),
    .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_pc(cpu_pc), .src_evt(src_evt), .src_en(src_en),
    .host_irq(host_irq), .host_stat(host_stat), .cpu_irq(cpu_irq), .bkpt_irq(bkpt_irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int hpos(input int i);
    int t[10] = '{15, 14, 13, 11, 9, 2, 7, 6, 4, 3};
    return t[i];
  endfunction

  function automatic logic [9:0] m_host(input logic [15:0] rt, input logic [9:0] e, input logic [9:0] n);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = e[i] & n[i] & rt[hpos(i)];
    return r;
  endfunction

  function automatic logic [9:0] m_cpu(input logic [15:0] rt, input logic [9:0] e, input logic [9:0] n);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = e[i] & n[i] & ~rt[hpos(i)];
    r[2] = e[2] & n[2] & rt[12];
    r[3] = e[3] & n[3] & rt[10];
    return r;
  endfunction

  task automatic hwrite(input logic sel, input logic [15:0] d);
    @(negedge clk);
    hst_sel = sel; hst_wr = 1'b1; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
    #1;
  endtask

  task automatic read_both(input logic sel, output logic [15:0] h, output logic [15:0] c);
    hst_sel = sel; cpu_sel = sel; #1;
    h = hst_rdata; c = cpu_rdata;
  endtask

  task automatic check_route(input string tag, input logic [15:0] rt, input logic [9:0] e, input logic [9:0] n);
    logic [9:0] eh;
    src_evt = e; src_en = n; #1;
    eh = m_host(rt, e, n);
    chk({tag, " host_stat"}, {6'd0, host_stat}, {6'd0, eh});
    chk({tag, " host_irq"}, {15'd0, host_irq}, {15'd0, |eh});
    chk({tag, " cpu_irq"}, {6'd0, cpu_irq}, {6'd0, m_cpu(rt, e, n)});
  endtask

  task automatic t_reset();
    logic [15:0] h, c;
    read_both(1'b0, h, c);
    chk("R1 bkpt host", h, 16'h0000); chk("R1 bkpt cpu", c, 16'h0000);
    read_both(1'b1, h, c);
    chk("R1 route host", h, 16'h1400); chk("R1 route cpu", c, 16'h1400);
    chk("R1 bkpt_irq", {15'd0, bkpt_irq}, 16'd0);
    chk("R1 outputs", {host_irq, 5'd0, cpu_irq}, 16'd0);
    chk("R1 host_stat", {6'd0, host_stat}, 16'd0);
  endtask

  task automatic t_host_rw();
    logic [15:0] h, c;
    hwrite(1'b0, 16'hBEEF);
    read_both(1'b0, h, c);
    chk("R2 bkpt host", h, 16'hBEEF); chk("R2 bkpt cpu", c, 16'hBEEF);
    hwrite(1'b1, 16'hA55A);
    read_both(1'b1, h, c);
    chk("R2 route host", h, 16'hA55A); chk("R2 route cpu", c, 16'hA55A);
    read_both(1'b0, h, c);
    chk("R2 bkpt untouched", h, 16'hBEEF);
  endtask

  task automatic t_rsvd();
    logic [15:0] h, c;
    hwrite(1'b1, 16'hFFFF);
    read_both(1'b1, h, c);
    chk("R6 bit5 zero", h, 16'hFFDF);
  endtask

  task automatic t_bkpt();
    hwrite(1'b0, 16'h0000);
    cpu_pc = 16'h0000;
    repeat (2) @(negedge clk);
    #1; chk("R4 zero never arms", {15'd0, bkpt_irq}, 16'd0);
    hwrite(1'b0, 16'h0100);
    cpu_pc = 16'h00FF;
    @(negedge clk); #1;
    chk("R4 no match", {15'd0, bkpt_irq}, 16'd0);
    cpu_pc = 16'h0100;
    @(negedge clk); #1;
    chk("R4 match sets", {15'd0, bkpt_irq}, 16'd1);
    cpu_pc = 16'h0300;
    repeat (2) @(negedge clk);
    #1; chk("R5 held after pc moves", {15'd0, bkpt_irq}, 16'd1);
    hwrite(1'b0, 16'h0200);
    chk("R5 held after rewrite", {15'd0, bkpt_irq}, 16'd1);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_sel = 1'b0; cpu_wdata = 16'h0000;
    @(negedge clk);
    cpu_wr = 1'b0; #1;
    chk("R3 cpu zero no clear", {15'd0, bkpt_irq}, 16'd1);
    hwrite(1'b0, 16'h0000);
    chk("R5 zero write clears", {15'd0, bkpt_irq}, 16'd0);
    @(negedge clk); #1;
    chk("R5 stays clear", {15'd0, bkpt_irq}, 16'd0);
  endtask

  task automatic t_cpu_write();
    logic [15:0] h, c;
    hwrite(1'b0, 16'h4321);
    hwrite(1'b1, 16'h1400);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_sel = 1'b0; cpu_wdata = 16'h1234;
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wdata = 16'hFFFF;
    @(negedge clk);
    cpu_wr = 1'b0; #1;
    read_both(1'b0, h, c);
    chk("R3 bkpt unchanged", h, 16'h4321);
    read_both(1'b1, h, c);
    chk("R3 route unchanged", h, 16'h1400);
    hwrite(1'b0, 16'h0000);
  endtask

  task automatic t_route_host();
    hwrite(1'b1, 16'hEADC);
    for (int i = 0; i < 10; i++) check_route("R7 one-hot host", 16'hEADC, 10'b1 << i, 10'h3FF);
  endtask

  task automatic t_route_cpu();
    hwrite(1'b1, 16'h0000);
    for (int i = 0; i < 10; i++) check_route("R8 one-hot cpu", 16'h0000, 10'b1 << i, 10'h3FF);
    check_route("R8 all events", 16'h0000, 10'h3FF, 10'h3FF);
  endtask

  task automatic t_sof();
    hwrite(1'b1, 16'h3400);
    check_route("R9 ch2 both, ch1 cpu", 16'h3400, 10'b00_0000_1100, 10'h3FF);
    hwrite(1'b1, 16'h0800);
    check_route("R9 ch1 host only", 16'h0800, 10'b00_0000_1100, 10'h3FF);
  endtask

  task automatic t_swap();
    logic [15:0] h, c;
    hwrite(1'b1, 16'h0101);
    read_both(1'b1, h, c);
    chk("R10 swap readback", h, 16'h0101);
    check_route("R10 swap no effect", 16'h0101, 10'h3FF, 10'h3FF);
  endtask

  task automatic t_disabled();
    hwrite(1'b1, 16'h6A94);
    check_route("R11 all disabled", 16'h6A94, 10'h3FF, 10'h000);
    check_route("R11 partial enable", 16'h6A94, 10'h3FF, 10'h155);
    check_route("R11 partial events", 16'h6A94, 10'h2B3, 10'h1CE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_host_rw();
    t_rsvd();
    t_bkpt();
    t_cpu_write();
    t_route_host();
    t_route_cpu();
    t_sof();
    t_swap();
    t_disabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule